// File: doc/BRIEF.md
# Time-Multiplexed Eight-Channel Rate Clock Distributor

This block lets one shared rate generator feed eight independent baud clock lines. A free-running scan counter walks the generator's select code through all eight upper codes, so the generator's single output presents a different divided frequency in each clock cycle. The returning sample is written into one bit of an eight-bit addressable latch. Each latch bit therefore follows one rate, refreshed once every eight clocks.

The generator registers its output, so a sample arrives one clock after the select code that asked for it. The latch address is the scan count delayed by that latency, modulo eight. Bit k of the output always holds the rate that select code k returned. A synchronous clear empties the latch without disturbing the scan. A generator channel whose half-period is a multiple of eight scan clocks is rebuilt with its exact period.

Top module: `rate_distributor`

## Requirements
- R1: While `rst_n` is low, `rate_clk` is all zeros and `sel` is 4'b1000 (scan count 0).
- R2: `sel[3]` is always 1, so only the upper eight select codes are used.
- R3: Outside reset, `sel[2:0]` increases by one, modulo 8, on every rising clock edge. This includes cycles with `clr` high.
- R4: On an edge with `clr` low, latch bit `(sel[2:0] - 1) mod 8` takes the value of `z_in`, where `sel` is the value before the edge. A generator that returns 1 only for select low bits equal to t therefore leaves only `rate_clk[t]` set.
- R5: On an edge with `clr` low, at most one bit of `rate_clk` changes.
- R6: On an edge with `clr` high, `rate_clk` becomes all zeros. Clear wins over the write due in the same cycle.
- R7: A clear does not pause or restart the scan. `sel` after a clear edge is one more than before it.
- R8: The generator may return, for select low bits k, a square wave that toggles every H_k scan clocks, where H_k is a multiple of 8 and is counted from reset. Then `rate_clk[k]` is a square wave of period 2*H_k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock (the generator's clock output) |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous latch clear |
| z_in | input | 1 | Registered multiplexed rate sample from the generator |
| sel | output | 4 | Select code to the generator; bit 3 held high |
| rate_clk | output | 8 | Rebuilt parallel rate clocks, bit k for select low bits k |

## Verification
A clear and a scheduled latch write can fall in the same edge. Every cycle carries a write, so any clear collides with one. The bench drives `z_in` high for all codes until the latch is full. It then raises `clr` for exactly one cycle and expects all zeros on the next sample, not one restored bit. In the same cycle it checks that `sel` still advanced by one, so the clear neither lost the write slot's address nor stalled the scan.

// File: rtl/rate_distributor.sv
module rate_distributor #(
  parameter int SCAN_W = 3,
  parameter int LAT    = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       z_in,
  output logic [SCAN_W:0]            sel,
  output logic [(1 << SCAN_W) - 1:0] rate_clk
);
  localparam int NCH = 1 << SCAN_W;
  localparam logic [SCAN_W-1:0] LAT_V = SCAN_W'(LAT);

  logic [SCAN_W-1:0] cnt;
  logic [SCAN_W-1:0] addr;

  assign sel  = {1'b1, cnt};
  assign addr = cnt - LAT_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rate_clk <= '0;
    else if (clr) rate_clk <= '0;
    else          rate_clk[addr] <= z_in;
  end

  logic unused_ok;
  assign unused_ok = (NCH > 0);
endmodule

// File: rtl/rate_distributor_chk.sv
module rate_distributor_chk #(
  parameter int SCAN_W = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clr,
  input logic                       z_in,
  input logic [SCAN_W:0]            sel,
  input logic [(1 << SCAN_W) - 1:0] rate_clk
);
  logic [SCAN_W-1:0] prev_addr;
  assign prev_addr = sel[SCAN_W-1:0] - 1'b1;

  p_reset_r1: assert property (@(posedge clk) !rst_n |-> (rate_clk == '0));
  p_sel_hi_r2: assert property (@(posedge clk) disable iff (!rst_n) sel[SCAN_W]);
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sel[SCAN_W-1:0] == $past(sel[SCAN_W-1:0]) + 1'b1));
  p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (rate_clk[$past(prev_addr)] == $past(z_in)));
  p_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($countones(rate_clk ^ $past(rate_clk)) <= 1));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rate_clk == '0));
endmodule

bind rate_distributor rate_distributor_chk #(.SCAN_W(SCAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .z_in(z_in), .sel(sel), .rate_clk(rate_clk)
);

// File: tb/rate_distributor_tb.sv
module rate_distributor_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic clr = 0;
  logic z_in;
  logic [3:0] sel;
  logic [7:0] rate_clk;

  int n_chk = 0;
  int n_bad = 0;
  int mode = 0;
  int tgt = 0;
  int tc;
  int cyc = 0;

  localparam int HALF [8] = '{8, 16, 24, 32, 40, 48, 56, 64};
  localparam int VEC_CH  [8] = '{3, 0, 7, 1, 5, 2, 6, 4};
  localparam int VEC_PER [8] = '{64, 16, 128, 32, 96, 48, 112, 80};

  int last_rise [8];
  int period [8];
  logic [7:0] prev_out;

  always #4 clk = ~clk;

  rate_distributor u_dut (.clk(clk), .rst_n(rst_n), .clr(clr), .z_in(z_in),
                          .sel(sel), .rate_clk(rate_clk));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc <= 0;
      z_in <= 1'b0;
    end else begin
      tc <= tc + 1;
      if (mode == 0)      z_in <= ((tc / HALF[sel[2:0]]) % 2) == 1;
      else if (mode == 1) z_in <= (int'(sel[2:0]) == tgt);
      else                z_in <= 1'b1;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) begin
      last_rise[k] = -1;
      period[k] = 0;
    end
    prev_out = '0;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int k = 0; k < 8; k++) begin
      if (rate_clk[k] && !prev_out[k]) begin
        if (last_rise[k] >= 0) period[k] = cyc - last_rise[k];
        last_rise[k] = cyc;
      end
    end
    prev_out = rate_clk;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] s0;
    int changes;
    logic [7:0] r0;
    cycles(3);
    check("R1 rate_clk", int'(rate_clk), 0);
    check("R1 sel", int'(sel), 8);
    rst_n = 1;
    cycles(1);
    for (int i = 0; i < 20; i++) begin
      s0 = sel;
      cycles(1);
      check("R2 sel3", int'(sel[3]), 1);
      check("R3 step", int'(sel[2:0]), int'(3'(s0[2:0] + 3'd1)));
    end
    cycles(600);
    for (int v = 0; v < 8; v++)
      check($sformatf("R8 period ch%0d", VEC_CH[v]), period[VEC_CH[v]], VEC_PER[v]);

    mode = 1; tgt = 5;
    cycles(20);
    check("R4 addr offset t5", int'(rate_clk), 8'h20);
    tgt = 0;
    cycles(20);
    check("R4 addr wrap t0", int'(rate_clk), 8'h01);

    tgt = 2;
    changes = 0;
    for (int i = 0; i < 16; i++) begin
      r0 = rate_clk;
      cycles(1);
      if ($countones(r0 ^ rate_clk) > 1) changes++;
    end
    check("R5 single bit per cycle", changes, 0);
    check("R4 addr t2", int'(rate_clk), 8'h04);

    mode = 2;
    cycles(20);
    check("R4 all written", int'(rate_clk), 8'hFF);
    s0 = sel;
    clr = 1;
    cycles(1);
    clr = 0;
    check("R6 clear beats write", int'(rate_clk), 0);
    check("R7 scan continues", int'(sel[2:0]), int'(3'(s0[2:0] + 3'd1)));
    cycles(1);
    check("R4 refill one bit", $countones(rate_clk), 1);
    cycles(8);
    check("R4 refill full", int'(rate_clk), 8'hFF);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule